// File: doc/BRIEF.md
# Cascadable BCD Decade Counter

A single synchronous decimal digit. On every clock edge where its enable input is high, the digit steps through the values 0 to 9 in binary-coded decimal and then returns to 0. When enable is low, the digit keeps its value. An active-high synchronous reset clears the digit.

The block also drives a carry output. The carry is high only while the decade is enabled and showing 9. To build a multi-digit decimal counter, connect each digit's carry to the enable of the next more significant digit. The next digit then steps on the same edge that takes this digit from 9 back to 0. A stalled digit never raises its carry.

The codes 10 to 15 do not occur in normal counting. If one ever appears, the next enabled edge takes the digit to 0.

Top module: `bcd_decade`

## Requirements
- R1: A clock edge with `rst` high sets `digit` to 0 (binary 0000), whatever the value of `en`.
- R2: On an edge with `rst` low, `en` high and `digit` in 0..8, `digit` becomes its previous value plus one.
- R3: On an edge with `rst` low, `en` high and `digit` equal to 9 (binary 1001), `digit` becomes 0.
- R4: On an edge with `rst` low and `en` low, `digit` keeps its value.
- R5: `carry` is a combinational output. It is 1 exactly when `en` is 1 and `digit` is 9, and it is 0 otherwise.
- R6: The next-value logic maps each unused code 10..15 to 0 when enabled, and holds it when not enabled.
- R7: When decades are chained, with each carry driving the next decade's enable, the chain counts in decimal. A more significant digit steps on the same edge on which the digit below it wraps from 9 to 0.
- R8: After reset, `digit` never leaves the range 0..9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable |
| digit | output | 4 | Present decimal digit in BCD |
| carry | output | 1 | High when enabled and at 9; enables the next decade |

## Verification
The single decade is run with a mixed enable pattern, so that runs of increments are interleaved with holds. Holds are placed just before 9, at 9 and just after the wrap, which separates step logic, wrap logic and hold logic. A reset applied mid-count with enable high shows that reset takes priority over counting. A three-digit chain driven continuously through 0..999 and back to 0 shows that each carry advances its neighbour on the wrap edge and not one cycle later. The next-value stage is also swept over all sixteen codes with enable both high and low, which covers the recovery from unused codes.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
    // Width of one decimal digit and its largest legal value.
    localparam int unsigned DEC_W   = 4;
    localparam int unsigned DEC_MAX = 9;

    typedef struct packed {
        logic [DEC_W-1:0] digit;
    } dec_state_t;
endpackage

// File: rtl/bcd_next.sv
module bcd_next #(
    parameter int unsigned W   = bcd_pkg::DEC_W,
    parameter int unsigned MAX = bcd_pkg::DEC_MAX
) (
    input  logic [W-1:0] cur,
    input  logic         en,
    output logic [W-1:0] nxt
);
    localparam logic [W-1:0] LAST = W'(MAX);

    // Wrap on the last legal code and also on any code above it.
    always_comb begin
        if (!en) begin
            nxt = cur;
        end else if (cur >= LAST) begin
            nxt = '0;
        end else begin
            nxt = cur + 1'b1;
        end
    end
endmodule

// File: rtl/bcd_carry.sv
module bcd_carry #(
    parameter int unsigned W   = bcd_pkg::DEC_W,
    parameter int unsigned MAX = bcd_pkg::DEC_MAX
) (
    input  logic [W-1:0] cur,
    input  logic         en,
    output logic         co
);
    localparam logic [W-1:0] LAST = W'(MAX);

    // Gated with enable so that a stalled digit holds its neighbour.
    always_comb begin
        co = en && (cur == LAST);
    end
endmodule

// File: rtl/bcd_decade.sv
module bcd_decade #(
    parameter int unsigned W   = bcd_pkg::DEC_W,
    parameter int unsigned MAX = bcd_pkg::DEC_MAX
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    output logic [W-1:0] digit,
    output logic         carry
);
    import bcd_pkg::*;

    dec_state_t state_d;
    dec_state_t state_q;
    logic [W-1:0] step_nxt;

    bcd_next #(.W(W), .MAX(MAX)) u_next (
        .cur (state_q.digit),
        .en  (en),
        .nxt (step_nxt)
    );

    bcd_carry #(.W(W), .MAX(MAX)) u_carry (
        .cur (state_q.digit),
        .en  (en),
        .co  (carry)
    );

    always_comb begin
        state_d       = state_q;
        state_d.digit = step_nxt;
        if (rst) begin
            state_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign digit = state_q.digit;
endmodule

// File: rtl/bcd_decade_chk.sv
module bcd_decade_chk #(
    parameter int unsigned W   = 4,
    parameter int unsigned MAX = 9
) (
    input logic         clk,
    input logic         rst,
    input logic         en,
    input logic [W-1:0] digit,
    input logic         carry
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (digit == '0));

    a_r2_step_up: assert property (@(posedge clk) disable iff (rst)
        (en && digit < W'(MAX)) |=> (digit == W'($past(digit) + 1'b1)));

    a_r3_wrap_zero: assert property (@(posedge clk) disable iff (rst)
        (en && digit == W'(MAX)) |=> (digit == '0));

    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(digit));

    a_r5_carry_only_at_last: assert property (@(posedge clk) disable iff (rst)
        carry |-> (en && digit == W'(MAX)));

    a_r5_carry_when_due: assert property (@(posedge clk) disable iff (rst)
        (en && digit == W'(MAX)) |-> carry);

    a_r8_in_range: assert property (@(posedge clk) disable iff (rst)
        digit <= W'(MAX));
endmodule

bind bcd_decade bcd_decade_chk #(.W(W), .MAX(MAX)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .digit (digit),
    .carry (carry)
);

// File: tb/tb_bcd_decade.sv
module tb_bcd_decade;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic [3:0] digit;
    logic       carry;

    // Three-digit chain.
    logic       crst = 1'b1;
    logic       cen  = 1'b0;
    logic [3:0] d0, d1, d2;
    logic       c0, c1, c2;

    // Stand-alone next-value stage for the code sweep.
    logic [3:0] nx_cur = '0;
    logic       nx_en  = 1'b0;
    logic [3:0] nx_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    bcd_decade dut (.clk(clk), .rst(rst), .en(en), .digit(digit), .carry(carry));
    bcd_decade u_c0 (.clk(clk), .rst(crst), .en(cen), .digit(d0), .carry(c0));
    bcd_decade u_c1 (.clk(clk), .rst(crst), .en(c0),  .digit(d1), .carry(c1));
    bcd_decade u_c2 (.clk(clk), .rst(crst), .en(c1),  .digit(d2), .carry(c2));
    bcd_next u_nx (.cur(nx_cur), .en(nx_en), .nxt(nx_out));

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // One cycle of the single decade: drive, check present outputs, advance the model.
    int exp_d = 0;
    task automatic cyc(input logic r, input logic e, input string req);
        @(negedge clk);
        rst = r;
        en  = e;
        #1;
        chk(digit == 4'(exp_d), req, digit, exp_d);
        chk(carry == (e && exp_d == 9), "R5 carry", carry, int'(e && exp_d == 9));
        chk(digit <= 4'd9, "R8 range", digit, 9);
        if (r)            exp_d = 0;
        else if (e)       exp_d = (exp_d == 9) ? 0 : exp_d + 1;
    endtask

    initial begin
        // R1: reset state
        cyc(1, 0, "R1 reset");
        cyc(1, 1, "R1 reset");
        chk(exp_d == 0, "R1 model", exp_d, 0);
        // R2/R3/R4: mixed enable, with holds near 9 and after the wrap
        for (int i = 0; i < 60; i++) begin
            logic e;
            e = !((i % 4) == 3) && !(i == 20 || i == 21 || i == 22);
            cyc(0, e, (i % 10 == 9) ? "R3 wrap" : ((i % 4) == 3 ? "R4 hold" : "R2 step"));
        end
        // R1: reset mid-count with enable high takes priority
        cyc(0, 1, "R2 step");
        cyc(1, 1, "R2 step");
        cyc(0, 0, "R1 mid reset");
        cyc(0, 1, "R4 hold after reset");
        cyc(0, 1, "R2 step");

        // R6: exhaustive next-value sweep
        for (int c = 0; c < 16; c++) begin
            for (int e = 0; e < 2; e++) begin
                int want;
                nx_cur = 4'(c);
                nx_en  = e[0];
                #1;
                want = (e == 0) ? c : ((c >= 9) ? 0 : c + 1);
                chk(nx_out == 4'(want), "R6 next", nx_out, want);
            end
        end

        // R7: three-digit chain counts 0..999 and wraps
        @(negedge clk);
        crst = 1'b1;
        cen  = 1'b0;
        @(negedge clk);
        crst = 1'b0;
        cen  = 1'b1;
        for (int v = 0; v < 1003; v++) begin
            int m;
            #1;
            m = v % 1000;
            chk(d0 == 4'(m % 10) && d1 == 4'((m / 10) % 10) && d2 == 4'(m / 100),
                "R7 chain", int'(d2) * 100 + int'(d1) * 10 + int'(d0), m);
            chk(c2 == (m == 999), "R7 top carry", c2, int'(m == 999));
            @(negedge clk);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule